// File: doc/BRIEF.md
# Voltage Island Power-Up Sequencer

This block brings up the voltage islands of a chip one at a time after a start request. It holds an island-enable register with one bit per island. A set bit switches power on to that island. On start, the block fills the register from the most significant end, one new bit per step, until every island is powered. This keeps the inrush current of each step below the supply limit.

A settling delay of its own sits in front of each step and is programmed in system-clock cycles. Heavy islands can be given a long gap and light islands a short one, so the current stays under the limit without stretching total start-up time. The island order is fixed by bit position: an island that must be powered before another sits at a higher index.

A synchronous shutdown clears the register in one cycle. An 8-bit host reads the 16-bit register as two halves. Reading the low half freezes the high half, so a two-read pair never returns a value that changed between the reads.

Top module: `island_pwr_seq`

## Requirements
- R1: While reset is active and after it is released, `island_en_o` is all zeros, `done_o` and `busy_o` are 0, and `rd_data_o` is 0.
- R2: A `start_i` high sampled while the sequencer is idle raises `busy_o` on that edge. The first island powers D0+2 clock edges later, counting the sampling edge as the first.
- R3: Each later step k powers its island D(k)+1 edges after step k-1. D(k) is the delay entry of step k, and a delay of 0 gives one step per cycle. Each step sets exactly one new bit.
- R4: Bit N_ISL-1 is set first and each step sets the next lower bit. After step k, the top k+1 bits are 1 and all other bits are 0.
- R5: A `start_i` pulse while a sequence is running, or while all islands are on, has no effect on the register, on step timing or on `busy_o`.
- R6: `shutdown_i` clears `island_en_o` to 0 on the next edge and returns the sequencer to idle. It takes priority over a `start_i` in the same cycle. Programmed delays are kept.
- R7: `done_o` rises in the same cycle in which bit 0 becomes 1. It stays high until a shutdown, and it is never high together with `busy_o`.
- R8: A `cfg_we_i` high writes `cfg_dly_i` into the delay entry of step `cfg_idx_i`. After reset every entry holds DLY_RST, which is 4 by default.
- R9: A read with `rd_en_i` high and `rd_sel_i`=0 returns bits [7:0] on `rd_data_o` on the following cycle and captures bits [15:8] at the same time. A read with `rd_sel_i`=1 returns that captured high half, not the live one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only when idle |
| shutdown_i | input | 1 | Synchronous clear of all islands |
| cfg_we_i | input | 1 | Delay entry write strobe |
| cfg_idx_i | input | 4 | Step index of the delay entry |
| cfg_dly_i | input | 8 | Delay value in cycles |
| rd_en_i | input | 1 | Host read strobe |
| rd_sel_i | input | 1 | 0 low half (captures high), 1 captured high half |
| rd_data_o | output | 8 | Registered host read data |
| island_en_o | output | 16 | Island power enables |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All islands powered |

## Verification
The bench measures the gap before every step against that step's own delay entry, using rising, flat and zero-delay profiles. A design that mixed up entries or miscounted by a cycle would land a step on the wrong edge. A start pulse in mid-run is checked so that a restarting design, which would reset the step counter and stretch the timing, is caught. A shutdown is sent together with a start to show that shutdown wins, and a start after completion is shown to leave the block idle. Two reads are straddled across a step that changes the high half, so a design that reads the live high half would return a torn value.

// File: rtl/ips_pkg.sv
package ips_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FULL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ips_dly_bank.sv
// Per-step settling delay storage with one write port and one read port.
module ips_dly_bank #(
  parameter int N_ENT   = 16,
  parameter int CNT_W   = 8,
  parameter int DLY_RST = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(N_ENT)-1:0] widx,
  input  logic [CNT_W-1:0]         wdata,
  input  logic [$clog2(N_ENT)-1:0] ridx,
  output logic [CNT_W-1:0]         rdata
);
  localparam int IW = $clog2(N_ENT);

  logic [CNT_W-1:0] ent_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic             hit;
    logic [CNT_W-1:0] ent_d;

    always_comb begin
      hit   = we && (widx == IW'(g));
      ent_d = ent_q[g];
      if (hit) ent_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= CNT_W'(DLY_RST);
      else if (hit) ent_q[g] <= ent_d;
    end
  end

  assign rdata = ent_q[ridx];
endmodule

// File: rtl/ips_step_timer.sv
// Down counter: loaded per step, expires when it reaches zero while running.
module ips_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/ips_thermo_reg.sv
// Island-enable register filled with ones from the MSB end.
module ips_thermo_reg #(
  parameter int N_ISL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  output logic [N_ISL-1:0] en_o
);
  logic [N_ISL-1:0] en_q, en_d;
  logic             en_ce;

  always_comb begin
    en_d  = en_q;
    en_ce = 1'b0;
    if (clr) begin
      en_d  = '0;
      en_ce = 1'b1;
    end else if (shift) begin
      en_d  = {1'b1, en_q[N_ISL-1:1]};
      en_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/ips_host_rd.sv
// Host readback in two halves; reading the low half freezes the high half.
module ips_host_rd #(
  parameter int N_ISL = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               rd_sel,
  input  logic [N_ISL-1:0]   vec,
  output logic [N_ISL/2-1:0] rd_data
);
  localparam int HW = N_ISL / 2;

  logic [HW-1:0] hold_q, hold_d, data_q, data_d;
  logic          hold_ce, data_ce;

  always_comb begin
    hold_d  = hold_q;
    hold_ce = 1'b0;
    data_d  = data_q;
    data_ce = 1'b0;
    if (rd_en) begin
      data_ce = 1'b1;
      if (!rd_sel) begin
        data_d  = vec[HW-1:0];
        hold_d  = vec[N_ISL-1:HW];
        hold_ce = 1'b1;
      end else begin
        data_d  = hold_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      data_q <= '0;
    end else begin
      if (hold_ce) hold_q <= hold_d;
      if (data_ce) data_q <= data_d;
    end
  end

  assign rd_data = data_q;
endmodule

// File: rtl/island_pwr_seq.sv
// Top: sequencing FSM plus the register, timer, delay bank and readback.
module island_pwr_seq #(
  parameter int N_ISL   = 16,
  parameter int CNT_W   = 8,
  parameter int DLY_RST = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     shutdown_i,
  input  logic                     cfg_we_i,
  input  logic [$clog2(N_ISL)-1:0] cfg_idx_i,
  input  logic [CNT_W-1:0]         cfg_dly_i,
  input  logic                     rd_en_i,
  input  logic                     rd_sel_i,
  output logic [N_ISL/2-1:0]       rd_data_o,
  output logic [N_ISL-1:0]         island_en_o,
  output logic                     busy_o,
  output logic                     done_o
);
  import ips_pkg::*;

  localparam int SW = $clog2(N_ISL);
  localparam logic [SW-1:0] LAST_STEP = SW'(N_ISL - 1);

  seq_state_e       st_q, st_d;
  logic [SW-1:0]    step_q, step_d;
  logic             step_ce;
  logic             accept, expire, fire, last;
  logic             tmr_load;
  logic [SW-1:0]    dly_idx;
  logic [CNT_W-1:0] dly_val;

  // control decode
  always_comb begin
    accept   = (st_q == SEQ_IDLE) && start_i && !shutdown_i;
    fire     = (st_q == SEQ_RUN) && expire && !shutdown_i;
    last     = fire && (step_q == LAST_STEP);
    tmr_load = accept || (fire && !last);
    dly_idx  = accept ? '0 : SW'(step_q + 1'b1);
  end

  // next state
  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    step_ce = 1'b0;
    if (shutdown_i) begin
      st_d    = SEQ_IDLE;
      step_d  = '0;
      step_ce = 1'b1;
    end else if (accept) begin
      st_d    = SEQ_RUN;
      step_d  = '0;
      step_ce = 1'b1;
    end else if (fire) begin
      step_d  = SW'(step_q + 1'b1);
      step_ce = 1'b1;
      if (last) st_d = SEQ_FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      step_q <= '0;
    end else begin
      st_q <= st_d;
      if (step_ce) step_q <= step_d;
    end
  end

  ips_dly_bank #(
    .N_ENT  (N_ISL),
    .CNT_W  (CNT_W),
    .DLY_RST(DLY_RST)
  ) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we_i),
    .widx (cfg_idx_i),
    .wdata(cfg_dly_i),
    .ridx (dly_idx),
    .rdata(dly_val)
  );

  ips_step_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(dly_val),
    .run     (st_q == SEQ_RUN),
    .expire  (expire)
  );

  ips_thermo_reg #(
    .N_ISL(N_ISL)
  ) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (shutdown_i),
    .shift(fire),
    .en_o (island_en_o)
  );

  ips_host_rd #(
    .N_ISL(N_ISL)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en_i),
    .rd_sel (rd_sel_i),
    .vec    (island_en_o),
    .rd_data(rd_data_o)
  );

  assign busy_o = (st_q == SEQ_RUN);
  assign done_o = (st_q == SEQ_FULL);
endmodule

// File: rtl/ips_checker.sv
module ips_checker #(
  parameter int N_ISL = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             shutdown_i,
  input logic [N_ISL-1:0] island_en_o,
  input logic             busy_o,
  input logic             done_o
);
  // R3: at most one new island per edge
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_i |=> ($countones(island_en_o) <= $countones($past(island_en_o)) + 1));

  // R4: bit i set implies bit i+1 set
  p_msb_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (island_en_o & ~{1'b1, island_en_o[N_ISL-1:1]}) == '0);

  // R6: shutdown empties the register and idles the block
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (island_en_o == '0) && !busy_o && !done_o);

  // R7: done is sticky until shutdown
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !shutdown_i) |=> done_o);

  // R7: done only with every island on
  p_done_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (&island_en_o));

  // R7: busy and done exclusive
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R5: start while complete changes nothing
  p_full_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && !shutdown_i) |=> done_o && !busy_o);
endmodule

bind island_pwr_seq ips_checker #(.N_ISL(N_ISL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .shutdown_i (shutdown_i),
  .island_en_o(island_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_island_pwr_seq.sv
module tb_island_pwr_seq;
  localparam int N = 16;

  logic        clk, rst_n;
  logic        start_i, shutdown_i, cfg_we_i, rd_en_i, rd_sel_i;
  logic [3:0]  cfg_idx_i;
  logic [7:0]  cfg_dly_i, rd_data_o;
  logic [15:0] island_en_o;
  logic        busy_o, done_o;

  int n_run, n_fail;
  int dexp [N];

  island_pwr_seq dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // base delay, increment per step, step after which a start is poked (FF none)
  localparam logic [23:0] VEC [4] = '{
    {8'd0, 8'd0, 8'hFF},
    {8'd1, 8'd2, 8'd3},
    {8'd9, 8'd0, 8'hFF},
    {8'd3, 8'd1, 8'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] thermo(input int k);
    return ~(16'hFFFF >> k);
  endfunction

  task automatic prog(input int idx, input int val);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(idx); cfg_dly_i = 8'(val);
    @(negedge clk);
    cfg_we_i = 1'b0;
    dexp[idx] = val;
  endtask

  task automatic pulse_shutdown();
    shutdown_i = 1'b1;
    @(negedge clk);
    shutdown_i = 1'b0;
  endtask

  // start a sequence and time every step against dexp
  task automatic run_seq(input string req, input int poke);
    logic [15:0] prev;
    int cyc;
    prev = island_en_o;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({"R2 busy ", req}, busy_o, 1);
    cyc = 1;
    for (int k = 0; k < N; k++) begin
      while (island_en_o == prev && cyc < 2000) begin
        @(negedge clk);
        start_i = 1'b0;
        cyc++;
      end
      check({"R3 step gap ", req}, cyc, (k == 0) ? dexp[0] + 2 : dexp[k] + 1);
      check({"R4 fill ", req}, island_en_o, thermo(k + 1));
      if (k == N - 1) check({"R7 done ", req}, done_o, 1);
      else if (k == 0 || k == 8) check({"R7 not done ", req}, done_o, 0);
      if (k == poke) start_i = 1'b1;  // R5: ignored mid-run
      prev = island_en_o;
      cyc = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 0; shutdown_i = 0; cfg_we_i = 0;
    cfg_idx_i = 0; cfg_dly_i = 0; rd_en_i = 0; rd_sel_i = 0;
    for (int i = 0; i < N; i++) dexp[i] = 4;
    repeat (3) @(negedge clk);
    check("R1 en in reset", island_en_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 en", island_en_o, 0);
    check("R1 done", done_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 rd", rd_data_o, 0);

    // R8: reset delay values used untouched
    run_seq("R8 default", -1);

    // R5: start after completion ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 busy after done", busy_o, 0);
    check("R5 en after done", island_en_o, 16'hFFFF);
    check("R7 done held", done_o, 1);

    // table walk
    foreach (VEC[v]) begin
      pulse_shutdown();
      check("R6 clear", island_en_o, 0);
      check("R7 done cleared", done_o, 0);
      for (int k = 0; k < N; k++)
        prog(k, (int'(VEC[v][23:16]) + int'(VEC[v][15:8]) * k) & 255);
      run_seq("R3 table", (VEC[v][7:0] == 8'hFF) ? -1 : int'(VEC[v][7:0]));
    end

    // R6: mid-run shutdown with simultaneous start
    pulse_shutdown();
    for (int k = 0; k < N; k++) prog(k, 5);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    check("R6 partially on", (island_en_o != 0) ? 1 : 0, 1);
    shutdown_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    shutdown_i = 1'b0; start_i = 1'b0;
    check("R6 cleared mid-run", island_en_o, 0);
    check("R6 idle", busy_o, 0);
    repeat (30) @(negedge clk);
    check("R6 stays off", island_en_o, 0);
    run_seq("R6 delays kept", -1);

    // R9: tear-free readback across a step
    pulse_shutdown();
    for (int k = 0; k < N; k++) prog(k, 6);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (island_en_o != 16'h8000) @(negedge clk);
    rd_en_i = 1'b1; rd_sel_i = 1'b0;
    @(negedge clk);
    rd_en_i = 1'b0;
    check("R9 low half", rd_data_o, 8'h00);
    while (island_en_o != 16'hC000) @(negedge clk);
    rd_en_i = 1'b1; rd_sel_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    check("R9 captured high", rd_data_o, 8'h80);
    while (!done_o) @(negedge clk);
    rd_en_i = 1'b1; rd_sel_i = 1'b0;
    @(negedge clk);
    rd_sel_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    check("R9 full high", rd_data_o, 8'hFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule